// File: doc/BRIEF.md
# Two-Group Interrupt Controller with Fixed Polling

This block sits next to a small processor core and decides which of five interrupt sources is delivered. The sources are external request 0, timer 0, external request 1, timer 1 and a serial port. The serial port raises a request when its transmit flag or its receive flag is set. Software configures two 8-bit registers through a simple write port. The arm register holds one enable per source and a master enable. The group register places each source in the high or the low group.

When requests are pending, the block picks one winner each cycle. A candidate in the high group beats any low-group candidate. Within a group, a fixed polling order settles ties. When a winner is accepted, the block emits a one-clock strobe with a 3-bit vector index and marks its group as in service. A request from the high group may nest over a running low-group handler. Nothing nests over a high-group handler. The core signals the end of a handler with a return strobe, which closes the most recently opened level.

Top module: `prio2_intc`

## Requirements
- R1: Both registers reset to 0x00. The group register (wr_sel=1) stores bits 4:0 and reads bits 7:5 as 0. The arm register (wr_sel=0) stores bits 7 and 4:0 and reads bits 6:5 as 0.
- R2: Source bit positions and vector indices are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial. src_req[3:0] carries sources 0 to 3. The serial request is ser_tx OR ser_rx.
- R3: A source is a candidate only when its arm bit and arm bit 7 (master enable) are both 1. With the master enable at 0, no strobe is issued.
- R4: A high-group candidate (group bit 1) is always chosen over a low-group candidate.
- R5: Among candidates of the same group, the lowest index wins.
- R6: irq_stb is high for exactly one clock, starting in the cycle after the accepted request is first visible at the inputs. irq_vec holds the winner's index while irq_stb is high.
- R7: Acceptance sets svc_lvl[0] for a low-group winner and svc_lvl[1] for a high-group winner. A high-group candidate is accepted while only svc_lvl[0] is set.
- R8: While svc_lvl[1] is set, no request is accepted. While svc_lvl[0] is set, low-group candidates wait.
- R9: A cycle with ret_stb high clears svc_lvl[1] if it is set, and clears svc_lvl[0] otherwise. No request is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the arm register, 1 selects the group register |
| wr_data | input | 8 | Write data |
| en_q | output | 8 | Arm register readback |
| grp_q | output | 8 | Group register readback |
| src_req | input | 4 | Requests from sources 0 to 3 |
| ser_tx | input | 1 | Serial transmit-done flag |
| ser_rx | input | 1 | Serial receive-done flag |
| ret_stb | input | 1 | Handler return strobe |
| irq_stb | output | 1 | One-clock interrupt delivery strobe |
| irq_vec | output | 3 | Vector index of the delivered source |
| svc_lvl | output | 2 | In-service flags: bit 0 low group, bit 1 high group |

## Verification
The bench sweeps all 31 non-empty request patterns under five group settings. An arbiter that ranks by index before group, or that polls in reverse, returns the wrong vector on mixed patterns. It also clears the master enable and single arm bits. A block that ignored either bit would deliver a strobe that should stay silent. The nesting sequence checks three things: a second low request waiting behind a low handler, a high request entering over it, and everything blocked under the high handler. A block with a single in-service flag would either refuse the nest or allow a same-group nest. Return strobes that close the wrong level show up in svc_lvl. Acceptance in the return cycle shows up as a stray strobe.

// File: rtl/prio2_intc_pkg.sv
// Package: shared sizes for the two-group interrupt controller.
// Assumes five sources. Register width and master-enable position are fixed here.
package prio2_intc_pkg;
    localparam int NSRC    = 5;
    localparam int VEC_W   = $clog2(NSRC);
    localparam int REG_W   = 8;
    localparam int GIE_BIT = 7;
    localparam logic [REG_W-1:0] SRC_MASK = REG_W'((1 << NSRC) - 1);
    localparam logic [REG_W-1:0] ARM_MASK = SRC_MASK | REG_W'(1 << GIE_BIT);
    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/prio2_intc_regs.sv
// Module: arm and group registers.
// Holds per-source arm bits, the master enable and the per-source group bits.
// Unimplemented bits read as zero and ignore writes.
module prio2_intc_regs
    import prio2_intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] en_q,
    output logic [REG_W-1:0] grp_q
);
    // Register update: masked write into the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            grp_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) grp_q <= wr_data & SRC_MASK;
            else        en_q  <= wr_data & ARM_MASK;
        end
    end
endmodule

// File: rtl/prio2_intc_arb.sv
// Module: fixed-order poller.
// Returns the lowest set index of a request vector and a found flag.
// Assumes W is wide enough to hold N-1.
module prio2_intc_arb #(
    parameter int N = 5,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);
    // Polling: scan from the highest index down so the lowest index wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/prio2_intc_nest.sv
// Module: acceptance and nesting control.
// Takes the winners of both groups and tracks the low and high in-service flags.
// Issues a registered one-clock strobe with the vector index.
// Assumes the return strobe closes the most recently opened level.
module prio2_intc_nest
    import prio2_intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_found,
    input  logic [VEC_W-1:0] hi_idx,
    input  logic             lo_found,
    input  logic [VEC_W-1:0] lo_idx,
    input  logic             ret_stb,
    output logic             irq_stb,
    output logic [VEC_W-1:0] irq_vec,
    output logic [1:0]       svc_lvl
);
    logic             take;
    logic             take_hi;
    logic [VEC_W-1:0] sel;

    // Acceptance decision: the high group first, blocked by a return or an open high level.
    always_comb begin
        take    = 1'b0;
        take_hi = 1'b0;
        sel     = '0;
        if (!ret_stb && !svc_lvl[1]) begin
            if (hi_found) begin
                take    = 1'b1;
                take_hi = 1'b1;
                sel     = hi_idx;
            end else if (!svc_lvl[0] && lo_found) begin
                take = 1'b1;
                sel  = lo_idx;
            end
        end
    end

    // State update: strobe, vector and in-service flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_stb <= 1'b0;
            irq_vec <= '0;
            svc_lvl <= '0;
        end else begin
            irq_stb <= take;
            if (take) irq_vec <= sel;
            if (ret_stb) begin
                if (svc_lvl[1]) svc_lvl[1] <= 1'b0;
                else            svc_lvl[0] <= 1'b0;
            end else if (take) begin
                if (take_hi) svc_lvl[1] <= 1'b1;
                else         svc_lvl[0] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/prio2_intc.sv
// Module: top of the two-group interrupt controller.
// Gates the raw requests with the arm bits and the master enable.
// Splits the candidates by group and polls each group in fixed order.
// The nest stage then accepts one winner per cycle.
module prio2_intc
    import prio2_intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] en_q,
    output logic [REG_W-1:0] grp_q,
    input  logic [3:0]       src_req,
    input  logic             ser_tx,
    input  logic             ser_rx,
    input  logic             ret_stb,
    output logic             irq_stb,
    output logic [VEC_W-1:0] irq_vec,
    output logic [1:0]       svc_lvl
);
    src_vec_t         raw;
    src_vec_t         cand;
    src_vec_t         hi_req;
    src_vec_t         lo_req;
    logic             hi_found;
    logic             lo_found;
    logic [VEC_W-1:0] hi_idx;
    logic [VEC_W-1:0] lo_idx;

    prio2_intc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .en_q(en_q), .grp_q(grp_q)
    );

    // Candidate forming: serial is the OR of its two flags, then arm and master gating.
    always_comb begin
        raw    = {ser_tx | ser_rx, src_req};
        cand   = raw & en_q[NSRC-1:0] & {NSRC{en_q[GIE_BIT]}};
        hi_req = cand & grp_q[NSRC-1:0];
        lo_req = cand & ~grp_q[NSRC-1:0];
    end

    prio2_intc_arb #(.N(NSRC), .W(VEC_W)) u_arb_hi (
        .req(hi_req), .found(hi_found), .idx(hi_idx)
    );

    prio2_intc_arb #(.N(NSRC), .W(VEC_W)) u_arb_lo (
        .req(lo_req), .found(lo_found), .idx(lo_idx)
    );

    prio2_intc_nest u_nest (
        .clk(clk), .rst_n(rst_n),
        .hi_found(hi_found), .hi_idx(hi_idx),
        .lo_found(lo_found), .lo_idx(lo_idx),
        .ret_stb(ret_stb),
        .irq_stb(irq_stb), .irq_vec(irq_vec), .svc_lvl(svc_lvl)
    );
endmodule

// File: rtl/prio2_intc_chk.sv
// Module: property checker bound to the controller top.
// Observes ports only.
module prio2_intc_chk
    import prio2_intc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] en_q,
    input logic [REG_W-1:0] grp_q,
    input logic             ret_stb,
    input logic             irq_stb,
    input logic [VEC_W-1:0] irq_vec,
    input logic [1:0]       svc_lvl
);
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        grp_q[7:5] == 3'b0 && en_q[6:5] == 2'b0);

    p_master_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[GIE_BIT] |=> !irq_stb);

    p_vec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stb |-> irq_vec < VEC_W'(NSRC));

    p_strobe_opens_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stb |-> svc_lvl != $past(svc_lvl));

    p_high_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        svc_lvl[1] && !ret_stb |=> !irq_stb && svc_lvl[1]);

    p_ret_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_stb |=> !irq_stb);

    p_ret_high_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_stb && svc_lvl[1] |=> !svc_lvl[1] && svc_lvl[0] == $past(svc_lvl[0]));
endmodule

bind prio2_intc prio2_intc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .grp_q(grp_q), .ret_stb(ret_stb),
    .irq_stb(irq_stb), .irq_vec(irq_vec), .svc_lvl(svc_lvl)
);

// File: tb/prio2_intc_bench.sv
// Bench: group sweeps over all request patterns, gating cases and a nesting sequence.
module prio2_intc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] en_q, grp_q;
    logic [3:0] src_req = '0;
    logic       ser_tx = 1'b0;
    logic       ser_rx = 1'b0;
    logic       ret_stb = 1'b0;
    logic       irq_stb;
    logic [2:0] irq_vec;
    logic [1:0] svc_lvl;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    prio2_intc u_prio2_intc (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .en_q(en_q), .grp_q(grp_q), .src_req(src_req), .ser_tx(ser_tx), .ser_rx(ser_rx),
        .ret_stb(ret_stb), .irq_stb(irq_stb), .irq_vec(irq_vec), .svc_lvl(svc_lvl)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wreg(input bit sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic drive(input logic [4:0] p, input bit use_rx);
        src_req = p[3:0];
        ser_tx  = p[4] & !use_rx;
        ser_rx  = p[4] & use_rx;
    endtask

    task automatic ret1();
        ret_stb = 1'b1;
        step();
        ret_stb = 1'b0;
    endtask

    // Expected winner: the high group if it has a request, then the lowest index.
    function automatic int winner(input logic [4:0] p, input logic [4:0] g);
        logic [4:0] pool = ((p & g) != 0) ? (p & g) : p;
        for (int i = 0; i < 5; i++) if (pool[i]) return i;
        return -1;
    endfunction

    initial begin
        logic [4:0] groups [5] = '{5'h00, 5'h06, 5'h1F, 5'h0A, 5'h15};
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(en_q, 0, "R1 arm reset");
        chk(grp_q, 0, "R1 group reset");
        chk(irq_stb, 0, "R6 strobe reset");
        chk(svc_lvl, 0, "R7 flags reset");

        wreg(1'b1, 8'hFF);
        chk(grp_q, 8'h1F, "R1 group reserved bits");
        wreg(1'b0, 8'hFF);
        chk(en_q, 8'h9F, "R1 arm reserved bits");

        // Sweep: every non-empty pattern under each group setting (R2 R4 R5 R6).
        foreach (groups[k]) begin
            wreg(1'b1, {3'b0, groups[k]});
            for (int p = 1; p < 32; p++) begin
                drive(5'(p), p[0]);
                step();
                chk(irq_stb, 1, "R6 strobe on request");
                chk(irq_vec, winner(5'(p), groups[k]), "R4 R5 winner vector");
                drive(5'h0, 1'b0);
                ret1();
                step();
            end
        end

        // Strobe lasts one clock with the request held (R6).
        wreg(1'b1, 8'h00);
        drive(5'h08, 1'b0);
        step();
        chk(irq_stb, 1, "R6 strobe rises");
        step();
        chk(irq_stb, 0, "R6 strobe one clock");
        drive(5'h0, 1'b0);
        ret1();

        // Master enable off (R3).
        wreg(1'b0, 8'h1F);
        drive(5'h1F, 1'b0);
        step(); step();
        chk(irq_stb, 0, "R3 master enable off");
        chk(svc_lvl, 0, "R3 no level opened");
        drive(5'h0, 1'b0);

        // Single arm bit clear: serial disarmed, only the serial flag via rx (R2 R3).
        wreg(1'b0, 8'h8F);
        drive(5'h10, 1'b1);
        step(); step();
        chk(irq_stb, 0, "R3 disarmed serial ignored");
        chk(svc_lvl, 0, "R3 disarmed serial no level");
        drive(5'h11, 1'b1);
        step();
        chk(irq_vec, 0, "R3 armed ext0 taken");
        drive(5'h0, 1'b0);
        ret1();

        // Nesting sequence (R7 R8 R9): ext1 high, the rest low.
        wreg(1'b0, 8'h9F);
        wreg(1'b1, 8'h04);
        drive(5'h02, 1'b0);
        step();
        chk(irq_vec, 1, "R7 low accepted");
        chk(svc_lvl, 1, "R7 low flag");
        drive(5'h03, 1'b0);
        step(); step();
        chk(irq_stb, 0, "R8 low waits under low");
        drive(5'h07, 1'b0);
        step();
        chk(irq_stb, 1, "R7 high nests");
        chk(irq_vec, 2, "R7 nest vector");
        chk(svc_lvl, 3, "R7 both flags");
        wreg(1'b1, 8'h05);
        step(); step();
        chk(irq_stb, 0, "R8 high blocks all");
        drive(5'h0, 1'b0);
        ret1();
        chk(svc_lvl, 1, "R9 return clears high first");
        ret1();
        chk(svc_lvl, 0, "R9 return clears low");

        // No acceptance in a return cycle (R9).
        drive(5'h04, 1'b0);
        ret_stb = 1'b1;
        step();
        ret_stb = 1'b0;
        chk(irq_stb, 0, "R9 no accept during return");
        step();
        chk(irq_stb, 1, "R9 accept after return");
        drive(5'h0, 1'b0);
        ret1();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule